// File: doc/BRIEF.md
# Half-Precision Division Fixup Unit

This unit is the last stage of a half-precision divide. An earlier stage produces a quotient estimate. This unit takes that estimate together with the original denominator and numerator and replaces the estimate wherever IEEE special-case rules decide the answer instead. Those cases are NaN operands, 0/0, infinity over infinity, division by zero, division by infinity, and an estimate that came out as NaN. In every other case the estimate leaves the unit unchanged.

Each input beat carries a valid strobe and an operation code. Only the divide-fixup code, 9'h1EF, is accepted. An accepted beat produces a registered result with a valid strobe one clock later. Any other beat leaves the output valid low and the output value unchanged.

The special cases are tested in a fixed order, from highest priority to lowest:

1. Denominator is NaN and the numerator is not.
2. Numerator is NaN.
3. Both operands are zero.
4. Both operands are infinite.
5. Denominator is zero.
6. Denominator is infinite.
7. The quotient estimate is NaN.

The first case that matches decides the result.

Top module: `hfix_div_fixup`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `out_result` is 16'h0000 until the first accepted beat.
- R2: A beat is accepted when `in_valid` is 1 and `in_opcode` equals 9'h1EF. The clock edge that samples an accepted beat sets `out_valid` to 1 and loads its result. `out_valid` is 0 after any edge that samples no accepted beat.
- R3: A beat with a different opcode, or with `in_valid` at 0, does not change `out_result`.
- R4: Values are classified by their fields: sign is bit 15, exponent is bits 14:10, mantissa is bits 9:0. NaN means the exponent is all ones and the mantissa is non-zero. Infinity means the exponent is all ones and the mantissa is zero. Zero means the exponent and mantissa are both zero, with either sign. If the denominator is NaN and the numerator is not NaN, the result is the denominator with bit 9 forced to 1. This check has the highest priority.
- R5: Otherwise, if the numerator is NaN, the result is the numerator with bit 9 forced to 1. This includes the case where both operands are NaN.
- R6: Otherwise, if both operands are zero, of either sign, the result is 16'h7E00.
- R7: Otherwise, if both operands are infinite, of any signs, the result is 16'hFE00.
- R8: Otherwise, if the denominator is zero, the result is infinity. Its sign bit is the XOR of the denominator and numerator sign bits, giving 16'h7C00 or 16'hFC00.
- R9: Otherwise, if the denominator is infinite, the result is zero. Its sign bit is the XOR of the two operand sign bits, giving 16'h0000 or 16'h8000.
- R10: Otherwise, if the quotient estimate is NaN, the result is infinity with the XOR of the denominator and numerator sign bits as its sign.
- R11: In every other case the result equals the quotient estimate bit for bit. This includes subnormal operands, which count as non-zero, a zero numerator over a finite denominator, and an infinite estimate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat strobe |
| in_opcode | input | 9 | Operation code; 9'h1EF selects the fixup |
| in_quot | input | 16 | Quotient estimate, half precision |
| in_den | input | 16 | Denominator, half precision |
| in_num | input | 16 | Numerator, half precision |
| out_valid | output | 1 | Result strobe, one clock after an accepted beat |
| out_result | output | 16 | Corrected half-precision result |

## Verification
Each priority level is driven with operand pairs that also satisfy one or more lower-priority rules. This shows whether the chain is ordered correctly, not only whether each rule exists. Examples are infinity over zero, zero over infinity, two NaNs, and a NaN estimate whose denominator is zero.

Both signs of zero and infinity are used, together with signalling and quiet NaN payloads. These patterns separate the sign-XOR logic from a fixed sign, and quieting from replacement by the canonical NaN. Subnormal denominators and infinite estimates confirm that values near the class boundaries fall through to the pass-through case. Rejected beats sent after an accepted one show whether the output value is held or overwritten.

// File: rtl/hfix_pkg.sv
package hfix_pkg;
    localparam int HW   = 16;
    localparam int EW   = 5;
    localparam int MW   = 10;
    localparam int OP_W = 9;
    localparam logic [OP_W-1:0] OP_FIXUP  = 9'h1EF;
    localparam logic [HW-1:0]   CANON_NAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};
    localparam logic [HW-1:0]   QUIET_MSK = {{(EW+1){1'b0}}, 1'b1, {(MW-1){1'b0}}};

    typedef struct packed {
        logic sign;
        logic is_nan;
        logic is_inf;
        logic is_zero;
    } hfix_class_t;

    typedef struct packed {
        logic          vld;
        logic [HW-1:0] res;
    } hfix_out_t;

    function automatic logic hfix_exp_max(input logic [HW-1:0] v);
        return &v[HW-2:MW];
    endfunction

    function automatic logic hfix_is_nan(input logic [HW-1:0] v);
        return hfix_exp_max(v) && (|v[MW-1:0]);
    endfunction
endpackage

// File: rtl/hfix_classify.sv
module hfix_classify
    import hfix_pkg::*;
(
    input  logic [HW-1:0] op,
    output hfix_class_t   cls
);
    always_comb begin
        cls.sign    = op[HW-1];
        cls.is_nan  = hfix_is_nan(op);
        cls.is_inf  = hfix_exp_max(op) && (op[MW-1:0] == '0);
        cls.is_zero = (op[HW-2:0] == '0);
    end
endmodule

// File: rtl/hfix_select.sv
module hfix_select
    import hfix_pkg::*;
(
    input  logic [HW-1:0] quot,
    input  logic [HW-1:0] den,
    input  logic [HW-1:0] num,
    input  hfix_class_t   den_c,
    input  hfix_class_t   num_c,
    output logic [HW-1:0] result
);
    logic          sgn;
    logic [HW-1:0] inf_val;
    logic [HW-1:0] zero_val;

    always_comb begin
        sgn      = den_c.sign ^ num_c.sign;
        inf_val  = {sgn, {EW{1'b1}}, {MW{1'b0}}};
        zero_val = {sgn, {(HW-1){1'b0}}};
        if (den_c.is_nan && !num_c.is_nan)
            result = den | QUIET_MSK;
        else if (num_c.is_nan)
            result = num | QUIET_MSK;
        else if (den_c.is_zero && num_c.is_zero)
            result = CANON_NAN;
        else if (den_c.is_inf && num_c.is_inf)
            result = CANON_NAN | {1'b1, {(HW-1){1'b0}}};
        else if (den_c.is_zero)
            result = inf_val;
        else if (den_c.is_inf)
            result = zero_val;
        else if (hfix_is_nan(quot))
            result = inf_val;
        else
            result = quot;
    end
endmodule

// File: rtl/hfix_div_fixup.sv
module hfix_div_fixup
    import hfix_pkg::*;
#(
    parameter logic [OP_W-1:0] OPCODE = OP_FIXUP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [OP_W-1:0] in_opcode,
    input  logic [HW-1:0]   in_quot,
    input  logic [HW-1:0]   in_den,
    input  logic [HW-1:0]   in_num,
    output logic            out_valid,
    output logic [HW-1:0]   out_result
);
    localparam int NCLS = 2;

    logic [NCLS-1:0][HW-1:0] cls_in;
    hfix_class_t [NCLS-1:0]  cls;
    logic [HW-1:0]           fix_res;
    logic                    accept;
    hfix_out_t               st_d, st_q;

    assign cls_in[0] = in_den;
    assign cls_in[1] = in_num;

    for (genvar g = 0; g < NCLS; g++) begin : g_cls
        hfix_classify u_cls (
            .op  (cls_in[g]),
            .cls (cls[g])
        );
    end

    hfix_select u_sel (
        .quot   (in_quot),
        .den    (in_den),
        .num    (in_num),
        .den_c  (cls[0]),
        .num_c  (cls[1]),
        .result (fix_res)
    );

    always_comb begin
        accept   = in_valid && (in_opcode == OPCODE);
        st_d     = st_q;
        st_d.vld = accept;
        if (accept)
            st_d.res = fix_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid  = st_q.vld;
    assign out_result = st_q.res;
endmodule

// File: rtl/hfix_div_fixup_chk.sv
module hfix_div_fixup_chk
    import hfix_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [OP_W-1:0] in_opcode,
    input logic [HW-1:0]   in_den,
    input logic [HW-1:0]   in_num,
    input logic            out_valid,
    input logic [HW-1:0]   out_result
);
    logic acc, d_nan, n_nan, d_zero, n_zero, d_inf, n_inf;
    always_comb begin
        acc    = in_valid && (in_opcode == OP_FIXUP);
        d_nan  = (in_den[14:10] == 5'h1F) && (in_den[9:0] != 10'h0);
        n_nan  = (in_num[14:10] == 5'h1F) && (in_num[9:0] != 10'h0);
        d_inf  = (in_den[14:0] == 15'h7C00);
        n_inf  = (in_num[14:0] == 15'h7C00);
        d_zero = (in_den[14:0] == 15'h0);
        n_zero = (in_num[14:0] == 15'h0);
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);
    a_r3_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> (!out_valid && $stable(out_result)));
    a_r4_quiet_den: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && d_nan && !n_nan) |=> (out_result == ($past(in_den) | 16'h0200)));
    a_r6_zero_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && d_zero && n_zero) |=> (out_result == 16'h7E00));
    a_r7_inf_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && d_inf && n_inf) |=> (out_result == 16'hFE00));
endmodule

bind hfix_div_fixup hfix_div_fixup_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_opcode  (in_opcode),
    .in_den     (in_den),
    .in_num     (in_num),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/sim_hfix_div_fixup.sv
`timescale 1ns/1ps
module sim_hfix_div_fixup;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [8:0]  in_opcode = 9'h0;
    logic [15:0] in_quot = 16'h0, in_den = 16'h0, in_num = 16'h0;
    logic        out_valid;
    logic [15:0] out_result;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    hfix_div_fixup u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
        .in_quot(in_quot), .in_den(in_den), .in_num(in_num),
        .out_valid(out_valid), .out_result(out_result)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic beat(input logic v, input logic [8:0] op,
                        input logic [15:0] q, input logic [15:0] d, input logic [15:0] n);
        @(negedge clk);
        in_valid = v; in_opcode = op; in_quot = q; in_den = d; in_num = n;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic fix(input string req, input logic [15:0] q, input logic [15:0] d,
                       input logic [15:0] n, input logic [15:0] exp);
        beat(1'b1, 9'h1EF, q, d, n);
        check({req, " valid"}, {15'h0, out_valid}, 16'h1);
        check(req, out_result, exp);
    endtask

    task automatic t_reset;
        check("R1 valid", {15'h0, out_valid}, 16'h0);
        check("R1 result", out_result, 16'h0);
    endtask

    task automatic t_den_nan;
        fix("R4 snan den", 16'h1234, 16'h7C01, 16'h3C00, 16'h7E01);
        fix("R4 neg den nan", 16'h1234, 16'hFD55, 16'h0000, 16'hFF55);
    endtask

    task automatic t_num_nan;
        fix("R5 num nan", 16'h3C00, 16'h3C00, 16'h7D00, 16'h7F00);
        fix("R5 both nan", 16'h3C00, 16'h7E11, 16'hFC05, 16'hFE05);
    endtask

    task automatic t_zero_zero;
        fix("R6 -0/+0", 16'h3C00, 16'h8000, 16'h0000, 16'h7E00);
        fix("R6 -0/-0", 16'h7E00, 16'h8000, 16'h8000, 16'h7E00);
    endtask

    task automatic t_inf_inf;
        fix("R7 -inf/+inf", 16'h3C00, 16'hFC00, 16'h7C00, 16'hFE00);
        fix("R7 +inf/+inf", 16'h0000, 16'h7C00, 16'h7C00, 16'hFE00);
    endtask

    task automatic t_div_zero;
        fix("R8 neg over +0", 16'h0000, 16'h0000, 16'hC000, 16'hFC00);
        fix("R8 -inf over -0", 16'h0000, 16'h8000, 16'hFC00, 16'h7C00);
    endtask

    task automatic t_div_inf;
        fix("R9 pos over +inf", 16'h3C00, 16'h7C00, 16'h4000, 16'h0000);
        fix("R9 -0 over +inf", 16'h3C00, 16'h7C00, 16'h8000, 16'h8000);
    endtask

    task automatic t_quot_nan;
        fix("R10 neg den", 16'h7E00, 16'hC000, 16'h4000, 16'hFC00);
        fix("R10 pos pos", 16'hFC01, 16'h3C00, 16'h3C00, 16'h7C00);
    endtask

    task automatic t_pass;
        fix("R11 plain", 16'h3800, 16'h4000, 16'h3C00, 16'h3800);
        fix("R11 subnormal den", 16'h7BFF, 16'h0001, 16'h3C00, 16'h7BFF);
        fix("R11 zero num", 16'h8000, 16'h3C00, 16'h0000, 16'h8000);
        fix("R11 inf quot", 16'h7C00, 16'h0400, 16'h7BFF, 16'h7C00);
    endtask

    task automatic t_reject;
        fix("R2 setup", 16'h3555, 16'h4000, 16'h3C00, 16'h3555);
        beat(1'b1, 9'h1EE, 16'h1111, 16'h0000, 16'h0000);
        check("R3 wrong op valid", {15'h0, out_valid}, 16'h0);
        check("R3 wrong op result", out_result, 16'h3555);
        beat(1'b0, 9'h1EF, 16'h2222, 16'h7C00, 16'h7C00);
        check("R2 idle valid", {15'h0, out_valid}, 16'h0);
        check("R3 idle result", out_result, 16'h3555);
    endtask

    initial begin
        #1;
        t_reset;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_den_nan;
        t_num_nan;
        t_zero_zero;
        t_inf_inf;
        t_div_zero;
        t_div_inf;
        t_quot_nan;
        t_pass;
        t_reject;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule